// File: doc/BRIEF.md
# Length-Based Receive Ring Selector

This block sits behind the receive datapath of an Ethernet controller and decides, for every completed frame, which of four receive descriptor rings gets it. Each ring has its own largest accepted frame length, its own descriptor count and an enable. When the receive side signals that a frame has been fully stored, the selector picks the smallest enabled ring that can hold the frame. It then issues one descriptor write carrying the frame length and status at that ring's head index, moves the head forward with wrap-around, and flags a per-ring completion interrupt.

Frames that fit no enabled ring are discarded and raise a sticky error flag. Frames whose target ring has no free descriptor are discarded and counted. Software hands descriptors back one at a time through a per-ring release strobe. Each interrupt can be enabled individually and is cleared by a per-ring clear strobe.

The control is a four-state machine. IDLE waits for the frame-end strobe and latches length and status (IDLE to PICK). PICK evaluates the ring choice and goes to WRITE when a ring fits and has a free descriptor, else back to IDLE after recording the drop. WRITE holds the write request until it is acknowledged (WRITE to COMMIT). COMMIT advances the head, books the descriptor as used and sets the pending interrupt (COMMIT to IDLE).

Top module: `rx_ring_steer`

## Requirements
- R1: A frame goes to the enabled ring with the smallest maximum length that is greater than or equal to the frame length; disabled rings are never chosen.
- R2: Each accepted frame produces exactly one descriptor write whose ring, index, length and status match the frame; the request stays high with stable fields until acknowledged.
- R3: The index written is the ring's head; after each write the head moves up by one and returns to 0 after index size-1, for ring sizes 1 to 16.
- R4: A frame longer than every enabled ring's maximum produces no write and sets the oversize flag, which stays set until reset.
- R5: When the chosen ring holds as many unreleased descriptors as its size, the frame produces no write and the overrun counter rises by one.
- R6: A release strobe for a ring frees one descriptor; a release for a ring with no used descriptor has no effect.
- R7: A ring's pending interrupt is set only when its descriptor write has completed, and is cleared by its clear strobe.
- R8: A ring's interrupt output shows its pending bit only while that ring's interrupt enable is 1; a pending bit survives while disabled.
- R9: A frame-end strobe arriving while a previous frame is still being handled is ignored.
- R10: After reset no write is requested, all interrupts are low, the oversize flag is 0 and the overrun counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_end | input | 1 | One-cycle strobe: a frame is fully stored |
| pkt_len | input | LEN_W | Frame length in bytes |
| pkt_status | input | STAT_W | Frame status word |
| cfg_max_len | input | N_RING*LEN_W | Per-ring maximum frame length, ring i in slice i |
| cfg_ring_size | input | N_RING*(IDX_W+1) | Per-ring descriptor count, 1 to 2**IDX_W |
| cfg_ring_en | input | N_RING | Per-ring enable |
| desc_release | input | N_RING | Per-ring strobe returning one descriptor |
| irq_en | input | N_RING | Per-ring interrupt enable |
| irq_clr | input | N_RING | Per-ring pending interrupt clear strobe |
| irq | output | N_RING | Per-ring completion interrupt |
| wr_req | output | 1 | Descriptor write request |
| wr_ack | input | 1 | Descriptor write accepted |
| wr_ring | output | $clog2(N_RING) | Ring of the descriptor being written |
| wr_index | output | IDX_W | Descriptor index within the ring |
| wr_len | output | LEN_W | Length written to the descriptor |
| wr_status | output | STAT_W | Status written to the descriptor |
| oversize_err | output | 1 | Sticky flag: a frame fit no enabled ring |
| overrun_cnt | output | CNT_W | Frames dropped for lack of a free descriptor |

## Verification
The bench builds the block with four rings of 64, 128, 256 and 2048 bytes and deliberately tiny ring sizes of 2, 3, 1 and 4 descriptors. Those sizes make head wrap-around, the single-descriptor ring and the full-ring drop reachable within a handful of frames. Ring limits are probed at their exact boundary and one byte past it, and toggling the enables moves frames to a larger ring or into the oversize path. A stalled acknowledge exposes the hold of the write request, the late interrupt and a second frame-end strobe arriving mid-write.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PICK,
        ST_WRITE,
        ST_COMMIT
    } steer_state_t;
endpackage

// File: rtl/rx_ring_pick.sv
// Combinational choice of the tightest enabled ring for a given length.
module rx_ring_pick #(
    parameter int N_RING = 4,
    parameter int LEN_W  = 12,
    parameter int RING_W = 2
) (
    input  logic [LEN_W-1:0]        len,
    input  logic [N_RING*LEN_W-1:0] max_len,
    input  logic [N_RING-1:0]       ring_en,
    output logic                    hit,
    output logic [RING_W-1:0]       ring_sel
);
    logic [LEN_W-1:0] best;
    logic [LEN_W-1:0] lim;

    always_comb begin
        hit      = 1'b0;
        ring_sel = '0;
        best     = '1;
        lim      = '0;
        for (int i = 0; i < N_RING; i++) begin
            lim = max_len[i*LEN_W +: LEN_W];
            if (ring_en[i] && (len <= lim) && (!hit || (lim < best))) begin
                hit      = 1'b1;
                best     = lim;
                ring_sel = RING_W'(i);
            end
        end
    end
endmodule

// File: rtl/rx_ring_track.sv
// Head index and used-descriptor count of one ring.
module rx_ring_track #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W:0]   cfg_size,
    input  logic             advance,
    input  logic             release_i,
    output logic [IDX_W-1:0] head,
    output logic             full
);
    localparam int SIZE_W = IDX_W + 1;

    logic [SIZE_W-1:0] used_q;
    logic [SIZE_W-1:0] last_idx;
    logic              rel_ok;

    assign last_idx = cfg_size - SIZE_W'(1);
    assign rel_ok   = release_i && (used_q != '0);
    assign full     = (used_q >= cfg_size);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head <= '0;
        end else if (advance) begin
            if ({1'b0, head} >= last_idx) head <= '0;
            else                          head <= head + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= '0;
        end else begin
            unique case ({advance, rel_ok})
                2'b10:   used_q <= used_q + SIZE_W'(1);
                2'b01:   used_q <= used_q - SIZE_W'(1);
                default: used_q <= used_q;
            endcase
        end
    end
endmodule

// File: rtl/rx_ring_steer.sv
module rx_ring_steer
    import rx_ring_pkg::*;
#(
    parameter int N_RING = 4,
    parameter int LEN_W  = 12,
    parameter int STAT_W = 8,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             pkt_end,
    input  logic [LEN_W-1:0]                 pkt_len,
    input  logic [STAT_W-1:0]                pkt_status,
    input  logic [N_RING*LEN_W-1:0]          cfg_max_len,
    input  logic [N_RING*(IDX_W+1)-1:0]      cfg_ring_size,
    input  logic [N_RING-1:0]                cfg_ring_en,
    input  logic [N_RING-1:0]                desc_release,
    input  logic [N_RING-1:0]                irq_en,
    input  logic [N_RING-1:0]                irq_clr,
    output logic [N_RING-1:0]                irq,
    output logic                             wr_req,
    input  logic                             wr_ack,
    output logic [$clog2(N_RING)-1:0]        wr_ring,
    output logic [IDX_W-1:0]                 wr_index,
    output logic [LEN_W-1:0]                 wr_len,
    output logic [STAT_W-1:0]                wr_status,
    output logic                             oversize_err,
    output logic [CNT_W-1:0]                 overrun_cnt
);
    localparam int RING_W = $clog2(N_RING);
    localparam int SIZE_W = IDX_W + 1;

    steer_state_t state_q, state_d;

    logic [LEN_W-1:0]  lat_len;
    logic [STAT_W-1:0] lat_status;
    logic [RING_W-1:0] lat_ring;
    logic [N_RING-1:0] pend_q;

    logic              pick_hit;
    logic [RING_W-1:0] pick_ring;
    logic [N_RING-1:0] full_v;
    logic [N_RING-1:0] adv_v;
    logic [IDX_W-1:0]  head_v [N_RING];
    logic              pick_ok;

    rx_ring_pick #(
        .N_RING (N_RING),
        .LEN_W  (LEN_W),
        .RING_W (RING_W)
    ) u_pick (
        .len      (lat_len),
        .max_len  (cfg_max_len),
        .ring_en  (cfg_ring_en),
        .hit      (pick_hit),
        .ring_sel (pick_ring)
    );

    for (genvar g = 0; g < N_RING; g++) begin : g_ring
        assign adv_v[g] = (state_q == ST_COMMIT) && (lat_ring == RING_W'(g));

        rx_ring_track #(
            .IDX_W (IDX_W)
        ) u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_size  (cfg_ring_size[g*SIZE_W +: SIZE_W]),
            .advance   (adv_v[g]),
            .release_i (desc_release[g]),
            .head      (head_v[g]),
            .full      (full_v[g])
        );
    end

    assign pick_ok = pick_hit && !full_v[pick_ring];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (pkt_end) state_d = ST_PICK;
            ST_PICK:   state_d = pick_ok ? ST_WRITE : ST_IDLE;
            ST_WRITE:  if (wr_ack) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        wr_req = 1'b0;
        unique case (state_q)
            ST_WRITE: wr_req = 1'b1;
            default:  wr_req = 1'b0;
        endcase
    end

    assign wr_ring   = lat_ring;
    assign wr_index  = head_v[lat_ring];
    assign wr_len    = lat_len;
    assign wr_status = lat_status;
    assign irq       = pend_q & irq_en;

    // Frame latch, drop bookkeeping and pending interrupts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_len      <= '0;
            lat_status   <= '0;
            lat_ring     <= '0;
            oversize_err <= 1'b0;
            overrun_cnt  <= '0;
            pend_q       <= '0;
        end else begin
            pend_q <= (pend_q & ~irq_clr) | adv_v;
            if ((state_q == ST_IDLE) && pkt_end) begin
                lat_len    <= pkt_len;
                lat_status <= pkt_status;
            end
            if (state_q == ST_PICK) begin
                if (!pick_hit) begin
                    oversize_err <= 1'b1;
                end else if (full_v[pick_ring]) begin
                    if (overrun_cnt != '1) overrun_cnt <= overrun_cnt + CNT_W'(1);
                end else begin
                    lat_ring <= pick_ring;
                end
            end
        end
    end
endmodule

// File: rtl/rx_ring_steer_chk.sv
module rx_ring_steer_chk #(
    parameter int N_RING = 4,
    parameter int LEN_W  = 12,
    parameter int STAT_W = 8,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_req,
    input logic                          wr_ack,
    input logic [$clog2(N_RING)-1:0]     wr_ring,
    input logic [IDX_W-1:0]              wr_index,
    input logic [LEN_W-1:0]              wr_len,
    input logic [STAT_W-1:0]             wr_status,
    input logic [N_RING*LEN_W-1:0]       cfg_max_len,
    input logic [N_RING*(IDX_W+1)-1:0]   cfg_ring_size,
    input logic                          oversize_err,
    input logic [CNT_W-1:0]              overrun_cnt
);
    localparam int SIZE_W = IDX_W + 1;

    logic [SIZE_W-1:0] sz_sel;
    logic [LEN_W-1:0]  lim_sel;

    assign sz_sel  = cfg_ring_size[wr_ring*SIZE_W +: SIZE_W];
    assign lim_sel = cfg_max_len[wr_ring*LEN_W +: LEN_W];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_ring) && $stable(wr_len) && $stable(wr_status))) // R2
        else $error("request dropped or changed before acknowledge");

    AST_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_len <= lim_sel)) // R1
        else $error("frame written to a ring too small for it");

    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ({1'b0, wr_index} < sz_sel)) // R3
        else $error("descriptor index beyond ring size");

    AST_OVERSIZE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        oversize_err |=> oversize_err) // R4
        else $error("oversize flag cleared without reset");

    AST_OVERRUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_cnt != $past(overrun_cnt)) |-> (overrun_cnt == $past(overrun_cnt) + CNT_W'(1))) // R5
        else $error("overrun counter moved by more than one");
endmodule

bind rx_ring_steer rx_ring_steer_chk #(
    .N_RING (N_RING),
    .LEN_W  (LEN_W),
    .STAT_W (STAT_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_req        (wr_req),
    .wr_ack        (wr_ack),
    .wr_ring       (wr_ring),
    .wr_index      (wr_index),
    .wr_len        (wr_len),
    .wr_status     (wr_status),
    .cfg_max_len   (cfg_max_len),
    .cfg_ring_size (cfg_ring_size),
    .oversize_err  (oversize_err),
    .overrun_cnt   (overrun_cnt)
);

// File: tb/test_rx_ring_steer.sv
`timescale 1ns/1ps
module test_rx_ring_steer;
    localparam int N_RING = 4;
    localparam int LEN_W  = 12;
    localparam int STAT_W = 8;
    localparam int IDX_W  = 4;
    localparam int CNT_W  = 8;
    localparam int SIZE_W = IDX_W + 1;

    logic                         clk = 1'b0;
    logic                         rst_n = 1'b0;
    logic                         pkt_end = 1'b0;
    logic [LEN_W-1:0]             pkt_len = '0;
    logic [STAT_W-1:0]            pkt_status = '0;
    logic [N_RING*LEN_W-1:0]      cfg_max_len;
    logic [N_RING*SIZE_W-1:0]     cfg_ring_size;
    logic [N_RING-1:0]            cfg_ring_en = 4'b1111;
    logic [N_RING-1:0]            desc_release = '0;
    logic [N_RING-1:0]            irq_en = 4'b0111;
    logic [N_RING-1:0]            irq_clr = '0;
    logic [N_RING-1:0]            irq;
    logic                         wr_req;
    logic                         wr_ack;
    logic [1:0]                   wr_ring;
    logic [IDX_W-1:0]             wr_index;
    logic [LEN_W-1:0]             wr_len;
    logic [STAT_W-1:0]            wr_status;
    logic                         oversize_err;
    logic [CNT_W-1:0]             overrun_cnt;
    logic                         stall = 1'b0;

    assign cfg_max_len   = {12'd2048, 12'd256, 12'd128, 12'd64};
    assign cfg_ring_size = {5'd4, 5'd1, 5'd3, 5'd2};
    assign wr_ack        = wr_req & ~stall;

    always #10 clk = ~clk;

    rx_ring_steer #(
        .N_RING (N_RING), .LEN_W (LEN_W), .STAT_W (STAT_W), .IDX_W (IDX_W), .CNT_W (CNT_W)
    ) i_rx_ring_steer (
        .clk (clk), .rst_n (rst_n), .pkt_end (pkt_end), .pkt_len (pkt_len),
        .pkt_status (pkt_status), .cfg_max_len (cfg_max_len), .cfg_ring_size (cfg_ring_size),
        .cfg_ring_en (cfg_ring_en), .desc_release (desc_release), .irq_en (irq_en),
        .irq_clr (irq_clr), .irq (irq), .wr_req (wr_req), .wr_ack (wr_ack),
        .wr_ring (wr_ring), .wr_index (wr_index), .wr_len (wr_len), .wr_status (wr_status),
        .oversize_err (oversize_err), .overrun_cnt (overrun_cnt)
    );

    int checks = 0;
    int errors = 0;

    // Write monitor
    int n_wr = 0;
    int cap_ring, cap_index, cap_len, cap_status;
    always @(negedge clk) begin
        if (wr_req && wr_ack) begin
            n_wr++;
            cap_ring   = int'(wr_ring);
            cap_index  = int'(wr_index);
            cap_len    = int'(wr_len);
            cap_status = int'(wr_status);
        end
    end

    // Model of ring occupancy
    int m_head [4] = '{0, 0, 0, 0};
    int m_size [4] = '{2, 3, 1, 4};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic m_write(input int r);
        m_head[r] = (m_head[r] == m_size[r] - 1) ? 0 : m_head[r] + 1;
    endtask

    task automatic send(input int len, input int st);
        @(negedge clk);
        pkt_end    = 1'b1;
        pkt_len    = LEN_W'(len);
        pkt_status = STAT_W'(st);
        @(negedge clk);
        pkt_end = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic release_one(input int r);
        @(negedge clk);
        desc_release[r] = 1'b1;
        @(negedge clk);
        desc_release = '0;
    endtask

    // Expected outcome code: 0..3 write to that ring, 4 oversize, 5 overrun
    typedef struct packed {
        logic [11:0] len;
        logic [2:0]  code;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{12'd64,   3'd0},
        '{12'd1,    3'd0},
        '{12'd65,   3'd1},
        '{12'd128,  3'd1},
        '{12'd200,  3'd2},
        '{12'd257,  3'd3},
        '{12'd2048, 3'd3},
        '{12'd2049, 3'd4},
        '{12'd10,   3'd5},
        '{12'd129,  3'd5}
    };

    task automatic expect_write(input int r, input int len, input int st, input int w0, input string tag);
        chk(n_wr == w0 + 1, {tag, " R2 one write"}, n_wr - w0, 1);
        chk(cap_ring == r, {tag, " R1 ring"}, cap_ring, r);
        chk(cap_index == m_head[r], {tag, " R3 index"}, cap_index, m_head[r]);
        chk(cap_len == len && cap_status == st, {tag, " R2 len"}, cap_len, len);
        m_write(r);
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0;
        int ov0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(wr_req == 1'b0 && irq == '0, "R10 idle outputs", int'(irq), 0);
        chk(oversize_err == 1'b0 && overrun_cnt == '0, "R10 error state", int'(overrun_cnt), 0);

        // Vector table
        for (int i = 0; i < 10; i++) begin
            w0  = n_wr;
            ov0 = int'(overrun_cnt);
            send(int'(VECS[i].len), 8'h30 + i);
            if (VECS[i].code < 3'd4) begin
                expect_write(int'(VECS[i].code), int'(VECS[i].len), 8'h30 + i, w0, "table");
            end else if (VECS[i].code == 3'd4) begin
                chk(n_wr == w0 && oversize_err, "R4 oversize drop", n_wr - w0, 0);
            end else begin
                chk(n_wr == w0 && int'(overrun_cnt) == ov0 + 1, "R5 overrun drop", int'(overrun_cnt), ov0 + 1);
            end
        end

        // R3 wrap / R6 release: ring0 wraps back to index 0
        release_one(0);
        w0 = n_wr;
        send(5, 8'hA0);
        expect_write(0, 5, 8'hA0, w0, "wrap");
        chk(m_head[0] == 1 && cap_index == 0, "R3 wrap to zero", cap_index, 0);
        chk(oversize_err == 1'b1, "R4 sticky", int'(oversize_err), 1);

        // R6 release on empty ring is ignored
        release_one(2);
        release_one(2);
        w0 = n_wr;
        send(150, 8'hA1);
        expect_write(2, 150, 8'hA1, w0, "rel");
        w0  = n_wr;
        ov0 = int'(overrun_cnt);
        send(160, 8'hA2);
        chk(n_wr == w0 && int'(overrun_cnt) == ov0 + 1, "R6 empty release ignored", int'(overrun_cnt), ov0 + 1);

        // R1 disabled ring skipped
        cfg_ring_en = 4'b1101;
        release_one(2);
        w0 = n_wr;
        send(100, 8'hA3);
        expect_write(2, 100, 8'hA3, w0, "disabled");

        // R4 oversize because the large ring is disabled
        cfg_ring_en = 4'b0111;
        w0 = n_wr;
        send(300, 8'hA4);
        chk(n_wr == w0 && oversize_err, "R4 no ring enabled big enough", n_wr - w0, 0);
        cfg_ring_en = 4'b1111;

        // R8 masking and R7 clear
        chk(irq == 4'b0111, "R8 masked ring hidden", int'(irq), 7);
        @(negedge clk);
        irq_en = 4'b1111;
        #1;
        chk(irq == 4'b1111, "R8 pending kept while masked", int'(irq), 15);
        @(negedge clk);
        irq_clr = 4'b1111;
        @(negedge clk);
        irq_clr = '0;
        #1;
        chk(irq == 4'b0000, "R7 clear", int'(irq), 0);

        // R2/R7/R9 stalled acknowledge
        stall = 1'b1;
        w0  = n_wr;
        ov0 = int'(overrun_cnt);
        send(100, 8'hB0);
        chk(wr_req == 1'b1 && n_wr == w0, "R2 request held while stalled", int'(wr_req), 1);
        chk(irq[1] == 1'b0, "R7 no interrupt before write done", int'(irq[1]), 0);
        send(10, 8'hB1);
        stall = 1'b0;
        repeat (4) @(negedge clk);
        expect_write(1, 100, 8'hB0, w0, "stall");
        chk(irq[1] == 1'b1, "R7 interrupt after write", int'(irq[1]), 1);
        repeat (4) @(negedge clk);
        chk(n_wr == w0 + 1 && int'(overrun_cnt) == ov0, "R9 strobe while busy ignored", n_wr - w0, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule